// File: doc/BRIEF.md
# ECC Error Capture Register

This block sits beside the read path of an SDRAM controller and keeps a record of the first ECC event it sees. Each read produces a strobe together with a corrected-error flag, an uncorrectable-error flag, the ECC syndrome and the read address. When no error is held, the first flagged read is latched: the upper address bits, the syndrome and which kind of error it was. That record stays frozen until software clears it.

Software reaches the block through one 32-bit register with a write strobe and a combinational read value. Three of its bits are read/write controls: one turns off scrubbing of corrected reads, one lets a captured uncorrectable error raise a bus-error level, and one lets a captured corrected error raise an NMI level. The two status bits are write-1-to-clear, and clearing either one clears both. Every corrected read also produces a one-cycle scrub request unless scrubbing is turned off. That request goes to a write-back path outside this block.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset the register reads 0x0000_0000 and scrub_req, bus_err and nmi are all low.
- R2: A register write loads bit 31 (scrub off), bit 3 (bus-error enable) and bit 2 (NMI enable) from the write data. Writes leave bits 30:4 unchanged.
- R3: When no error is held, a strobe with a flag set captures the error. From the next cycle bits 30:12 hold read address bits 31:13, bits 11:4 hold the syndrome, and bit 0 (corrected) or bit 1 (uncorrectable) is set.
- R4: While bit 0 or bit 1 is set, later flagged strobes of either type change no bit of the register.
- R5: A write with 1 in bit 0 or bit 1 clears both status bits, and the address and syndrome fields keep their values. A write with 0 in both bits leaves the status unchanged.
- R6: If a clearing write and a flagged strobe arrive in the same cycle, the new error is captured.
- R7: A strobe with both flags set is captured as uncorrectable: bit 1 is set and bit 0 stays 0.
- R8: bus_err is a level equal to bit 3 AND bit 1. nmi is a level equal to bit 2 AND bit 0. Both follow the register in the same cycle.
- R9: scrub_req is high for exactly the one cycle after a strobe that has only the corrected flag set, when bit 31 was 0 at that strobe. This holds whether or not the error is captured.
- R10: A strobe with neither flag set captures nothing and requests no scrub.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | One read result is present this cycle |
| rd_sbe | input | 1 | The read had a corrected single-bit error |
| rd_mbe | input | 1 | The read had an uncorrectable error |
| rd_syndrome | input | 8 | ECC syndrome of the read |
| rd_addr | input | 32 | Byte address of the read |
| csr_wr | input | 1 | Register write strobe |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Current register value |
| scrub_req | output | 1 | One-cycle scrub request for a corrected read |
| bus_err | output | 1 | Bus-error level |
| nmi | output | 1 | NMI level |

## Verification
The capture of a strobe, a clear, and the writing of control bits all show up in csr_rdata one clock edge after the stimulus. scrub_req is also registered, so it is high in that same next cycle and low in the cycle after. bus_err and nmi are combinational from the register, so they change in the same cycle as the register bits they depend on. Each bench task drives its inputs on a falling edge and checks every output at the following falling edge, which comes after exactly one rising edge. Scrub checks then sample one more falling edge later to confirm that the pulse has ended.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;

   typedef enum logic [1:0] {
      EV_NONE = 2'd0,
      EV_CORR = 2'd1,
      EV_UNCR = 2'd2
   } ev_kind_e;

   // An uncorrectable flag wins over a corrected flag on the same read.
   function automatic ev_kind_e classify(input logic vld, input logic sbe, input logic mbe);
      ev_kind_e k;
      k = EV_NONE;
      if (vld && mbe)      k = EV_UNCR;
      else if (vld && sbe) k = EV_CORR;
      return k;
   endfunction

endpackage

// File: rtl/ecc_cap_ctrl.sv
module ecc_cap_ctrl #(
   parameter int REG_W     = 32,
   parameter int SCRUB_BIT = 31,
   parameter int BUS_BIT   = 3,
   parameter int NMI_BIT   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   output logic             scrub_off,
   output logic             bus_en,
   output logic             nmi_en
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scrub_off <= 1'b0;
         bus_en    <= 1'b0;
         nmi_en    <= 1'b0;
      end else if (wr) begin
         scrub_off <= wdata[SCRUB_BIT];
         bus_en    <= wdata[BUS_BIT];
         nmi_en    <= wdata[NMI_BIT];
      end
   end

endmodule

// File: rtl/ecc_cap_latch.sv
module ecc_cap_latch
   import ecc_cap_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int SYN_W     = 8,
   parameter int ADDR_KEEP = 19
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  ev_kind_e             kind,
   input  logic [SYN_W-1:0]     ev_syn,
   input  logic [ADDR_W-1:0]    ev_addr,
   input  logic                 clr_req,
   output logic                 corr_st,
   output logic                 uncr_st,
   output logic [ADDR_KEEP-1:0] cap_addr,
   output logic [SYN_W-1:0]     cap_syn
);

   logic held;
   logic open_w;
   logic take;

   assign held   = corr_st | uncr_st;
   assign open_w = clr_req | ~held;
   assign take   = open_w & (kind != EV_NONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         corr_st  <= 1'b0;
         uncr_st  <= 1'b0;
         cap_addr <= '0;
         cap_syn  <= '0;
      end else if (take) begin
         corr_st  <= (kind == EV_CORR);
         uncr_st  <= (kind == EV_UNCR);
         cap_addr <= ev_addr[ADDR_W-1 -: ADDR_KEEP];
         cap_syn  <= ev_syn;
      end else if (clr_req) begin
         corr_st  <= 1'b0;
         uncr_st  <= 1'b0;
      end
   end

endmodule

// File: rtl/ecc_cap_alert.sv
module ecc_cap_alert
   import ecc_cap_pkg::*;
#(
   parameter bit OUT_REG = 1'b0
) (
   input  logic     clk,
   input  logic     rst_n,
   input  ev_kind_e kind,
   input  logic     scrub_off,
   input  logic     bus_en,
   input  logic     nmi_en,
   input  logic     corr_st,
   input  logic     uncr_st,
   output logic     scrub_req,
   output logic     bus_err,
   output logic     nmi
);

   always_ff @(posedge clk) begin
      if (!rst_n) scrub_req <= 1'b0;
      else        scrub_req <= (kind == EV_CORR) & ~scrub_off;
   end

   generate
      if (OUT_REG) begin : g_lvl_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               bus_err <= 1'b0;
               nmi     <= 1'b0;
            end else begin
               bus_err <= bus_en & uncr_st;
               nmi     <= nmi_en & corr_st;
            end
         end
      end else begin : g_lvl_comb
         assign bus_err = bus_en & uncr_st;
         assign nmi     = nmi_en & corr_st;
      end
   endgenerate

endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
   import ecc_cap_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int SYN_W     = 8,
   parameter int ADDR_KEEP = 19,
   parameter bit OUT_REG   = 1'b0,
   localparam int REG_W    = ADDR_KEEP + SYN_W + 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_valid,
   input  logic              rd_sbe,
   input  logic              rd_mbe,
   input  logic [SYN_W-1:0]  rd_syndrome,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              csr_wr,
   input  logic [REG_W-1:0]  csr_wdata,
   output logic [REG_W-1:0]  csr_rdata,
   output logic              scrub_req,
   output logic              bus_err,
   output logic              nmi
);

   localparam int CORR_BIT  = 0;
   localparam int UNCR_BIT  = 1;
   localparam int NMI_BIT   = 2;
   localparam int BUS_BIT   = 3;
   localparam int SYN_LO    = 4;
   localparam int ADDR_LO   = SYN_LO + SYN_W;
   localparam int SCRUB_BIT = ADDR_LO + ADDR_KEEP;

   initial begin : p_param_chk
      assert (ADDR_KEEP >= 1 && ADDR_KEEP <= ADDR_W)
         else $error("ADDR_KEEP must lie within 1..ADDR_W");
      assert (SYN_W >= 1)
         else $error("SYN_W must be at least 1");
      assert (SCRUB_BIT == REG_W - 1)
         else $error("register layout does not fill REG_W");
   end

   ev_kind_e               kind;
   logic                   clr_req;
   logic                   scrub_off;
   logic                   bus_en;
   logic                   nmi_en;
   logic                   corr_st;
   logic                   uncr_st;
   logic [ADDR_KEEP-1:0]   cap_addr;
   logic [SYN_W-1:0]       cap_syn;

   assign kind    = classify(rd_valid, rd_sbe, rd_mbe);
   assign clr_req = csr_wr & (csr_wdata[CORR_BIT] | csr_wdata[UNCR_BIT]);

   ecc_cap_ctrl #(
      .REG_W     (REG_W),
      .SCRUB_BIT (SCRUB_BIT),
      .BUS_BIT   (BUS_BIT),
      .NMI_BIT   (NMI_BIT)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (csr_wr),
      .wdata     (csr_wdata),
      .scrub_off (scrub_off),
      .bus_en    (bus_en),
      .nmi_en    (nmi_en)
   );

   ecc_cap_latch #(
      .ADDR_W    (ADDR_W),
      .SYN_W     (SYN_W),
      .ADDR_KEEP (ADDR_KEEP)
   ) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .kind     (kind),
      .ev_syn   (rd_syndrome),
      .ev_addr  (rd_addr),
      .clr_req  (clr_req),
      .corr_st  (corr_st),
      .uncr_st  (uncr_st),
      .cap_addr (cap_addr),
      .cap_syn  (cap_syn)
   );

   ecc_cap_alert #(
      .OUT_REG (OUT_REG)
   ) u_alert (
      .clk       (clk),
      .rst_n     (rst_n),
      .kind      (kind),
      .scrub_off (scrub_off),
      .bus_en    (bus_en),
      .nmi_en    (nmi_en),
      .corr_st   (corr_st),
      .uncr_st   (uncr_st),
      .scrub_req (scrub_req),
      .bus_err   (bus_err),
      .nmi       (nmi)
   );

   assign csr_rdata = {scrub_off, cap_addr, cap_syn, bus_en, nmi_en, uncr_st, corr_st};

endmodule

// File: rtl/ecc_cap_checker.sv
module ecc_cap_checker #(
   parameter int REG_W   = 32,
   parameter bit OUT_REG = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rd_valid,
   input logic             rd_sbe,
   input logic             rd_mbe,
   input logic             csr_wr,
   input logic [REG_W-1:0] csr_wdata,
   input logic [REG_W-1:0] csr_rdata,
   input logic             scrub_req,
   input logic             bus_err,
   input logic             nmi
);

   logic st;
   logic clr;
   logic flagged;

   assign st      = csr_rdata[0] | csr_rdata[1];
   assign clr     = csr_wr & (csr_wdata[0] | csr_wdata[1]);
   assign flagged = rd_valid & (rd_sbe | rd_mbe);

   assert_status_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(csr_rdata[1:0]));

   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st && !csr_wr) |=> $stable(csr_rdata));

   assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !flagged) |=> (csr_rdata[1:0] == 2'b00));

   assert_keep_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_wr && csr_wdata[1:0] == 2'b00 && !flagged) |=> (csr_rdata[1:0] == $past(csr_rdata[1:0])));

   assert_clear_then_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flagged && (clr || !st)) |=> (csr_rdata[1:0] != 2'b00));

   assert_both_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_sbe && rd_mbe && (clr || !st)) |=> (csr_rdata[1:0] == 2'b10));

   assert_scrub_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      scrub_req |-> $past(rd_valid && rd_sbe && !rd_mbe && !csr_rdata[REG_W-1]));

   assert_no_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_sbe && !rd_mbe && !st && !csr_wr) |=> (csr_rdata[1:0] == 2'b00 && !scrub_req));

   generate
      if (!OUT_REG) begin : g_lvl_chk
         assert_bus_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
            bus_err == (csr_rdata[3] && csr_rdata[1]));
         assert_nmi_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
            nmi == (csr_rdata[2] && csr_rdata[0]));
      end
   endgenerate

endmodule

bind ecc_err_capture ecc_cap_checker #(
   .REG_W   (REG_W),
   .OUT_REG (OUT_REG)
) u_ecc_cap_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_valid  (rd_valid),
   .rd_sbe    (rd_sbe),
   .rd_mbe    (rd_mbe),
   .csr_wr    (csr_wr),
   .csr_wdata (csr_wdata),
   .csr_rdata (csr_rdata),
   .scrub_req (scrub_req),
   .bus_err   (bus_err),
   .nmi       (nmi)
);

// File: tb/ecc_err_capture_bench.sv
`timescale 1ns/1ps
module ecc_err_capture_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_valid = 1'b0;
   logic        rd_sbe = 1'b0;
   logic        rd_mbe = 1'b0;
   logic [7:0]  rd_syndrome = '0;
   logic [31:0] rd_addr = '0;
   logic        csr_wr = 1'b0;
   logic [31:0] csr_wdata = '0;
   logic [31:0] csr_rdata;
   logic        scrub_req;
   logic        bus_err;
   logic        nmi;

   int n_checks = 0;
   int n_fail   = 0;

   // model state derived from the requirements
   logic        m_off = 0, m_ben = 0, m_nen = 0, m_corr = 0, m_uncr = 0;
   logic [18:0] m_addr = '0;
   logic [7:0]  m_syn = '0;
   logic        m_scrub = 0;

   always #4 clk = ~clk;

   ecc_err_capture u_ecc_err_capture (
      .clk (clk), .rst_n (rst_n),
      .rd_valid (rd_valid), .rd_sbe (rd_sbe), .rd_mbe (rd_mbe),
      .rd_syndrome (rd_syndrome), .rd_addr (rd_addr),
      .csr_wr (csr_wr), .csr_wdata (csr_wdata), .csr_rdata (csr_rdata),
      .scrub_req (scrub_req), .bus_err (bus_err), .nmi (nmi)
   );

   function automatic logic [31:0] m_reg();
      return {m_off, m_addr, m_syn, m_ben, m_nen, m_uncr, m_corr};
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic chk_all(input string req);
      chk(req, "rdata", csr_rdata, m_reg());
      chk(req, "scrub_req", {31'b0, scrub_req}, {31'b0, m_scrub});
      chk(req, "bus_err", {31'b0, bus_err}, {31'b0, m_ben & m_uncr});
      chk(req, "nmi", {31'b0, nmi}, {31'b0, m_nen & m_corr});
   endtask

   // one cycle of stimulus, starting and ending on a falling edge
   task automatic step(input logic v, input logic s, input logic m, input logic [7:0] syn,
                       input logic [31:0] a, input logic w, input logic [31:0] wd);
      logic clr, hit;
      rd_valid = v; rd_sbe = s; rd_mbe = m; rd_syndrome = syn; rd_addr = a;
      csr_wr = w; csr_wdata = wd;
      m_scrub = v & s & ~m & ~m_off;
      clr = w & (wd[0] | wd[1]);
      hit = v & (s | m);
      if (hit && (clr || !(m_corr || m_uncr))) begin
         m_uncr = m; m_corr = ~m; m_addr = a[31:13]; m_syn = syn;
      end else if (clr) begin
         m_corr = 0; m_uncr = 0;
      end
      if (w) begin m_off = wd[31]; m_ben = wd[3]; m_nen = wd[2]; end
      @(negedge clk);
      rd_valid = 0; rd_sbe = 0; rd_mbe = 0; csr_wr = 0;
   endtask

   task automatic idle_check(input string req);
      step(0, 0, 0, 8'h00, 32'h0, 0, 32'h0);
      chk_all(req);
   endtask

   task automatic t_reset();
      chk_all("R1");
   endtask

   task automatic t_ctrl_bits();
      step(0, 0, 0, 8'h00, 32'h0, 1, 32'hFFFF_FFFF);
      chk("R2", "rdata after all-ones write", csr_rdata, 32'h8000_000C);
      step(0, 0, 0, 8'h00, 32'h0, 1, 32'h0000_0000);
      chk("R2", "rdata after zero write", csr_rdata, 32'h0000_0000);
   endtask

   task automatic t_corr_capture();
      step(0, 0, 0, 8'h00, 32'h0, 1, 32'h0000_000C);
      step(1, 1, 0, 8'h5A, 32'hDEAD_BEEF, 0, 32'h0);
      chk_all("R3");
      chk("R8", "nmi level", {31'b0, nmi}, 32'h1);
      chk("R9", "scrub pulse", {31'b0, scrub_req}, 32'h1);
      idle_check("R9");
   endtask

   task automatic t_hold();
      step(1, 0, 1, 8'hC3, 32'h1234_5678, 0, 32'h0);
      chk_all("R4");
      step(1, 1, 0, 8'h11, 32'h0F0F_0000, 0, 32'h0);
      chk_all("R4");
      chk("R9", "scrub while held", {31'b0, scrub_req}, 32'h1);
   endtask

   task automatic t_clear();
      step(0, 0, 0, 8'h00, 32'h0, 1, 32'h0000_000C);
      chk_all("R5");
      chk("R5", "status kept", {30'b0, csr_rdata[1:0]}, 32'h1);
      step(0, 0, 0, 8'h00, 32'h0, 1, 32'h0000_000E);
      chk_all("R5");
      chk("R5", "status cleared", {30'b0, csr_rdata[1:0]}, 32'h0);
   endtask

   task automatic t_uncr_capture();
      step(1, 0, 1, 8'hA7, 32'hF000_2000, 0, 32'h0);
      chk_all("R3");
      chk("R8", "bus_err level", {31'b0, bus_err}, 32'h1);
      chk("R9", "no scrub on uncorrectable", {31'b0, scrub_req}, 32'h0);
      step(0, 0, 0, 8'h00, 32'h0, 1, 32'h0000_0005);
      chk_all("R8");
   endtask

   task automatic t_both_flags();
      step(1, 1, 1, 8'h3C, 32'h8000_6000, 0, 32'h0);
      chk_all("R7");
      chk("R7", "status field", {30'b0, csr_rdata[1:0]}, 32'h2);
   endtask

   task automatic t_same_cycle();
      step(1, 1, 0, 8'h99, 32'h4444_E000, 1, 32'h0000_0007);
      chk_all("R6");
      chk("R6", "status field", {30'b0, csr_rdata[1:0]}, 32'h1);
   endtask

   task automatic t_scrub_off();
      step(0, 0, 0, 8'h00, 32'h0, 1, 32'h8000_0003);
      chk_all("R2");
      step(1, 1, 0, 8'h21, 32'h0000_4000, 0, 32'h0);
      chk_all("R9");
      chk("R9", "scrub disabled", {31'b0, scrub_req}, 32'h0);
   endtask

   task automatic t_no_flag();
      step(0, 0, 0, 8'h00, 32'h0, 1, 32'h0000_0003);
      step(1, 0, 0, 8'hFF, 32'hFFFF_FFFF, 0, 32'h0);
      chk_all("R10");
      chk("R10", "status field", {30'b0, csr_rdata[1:0]}, 32'h0);
   endtask

   task automatic t_ro_write();
      step(0, 0, 0, 8'h00, 32'h0, 1, 32'h7FFF_FFF0);
      chk_all("R2");
   endtask

   initial begin : p_watchdog
      #(8ns * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
      $finish;
   end

   initial begin : p_main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ctrl_bits();
      t_corr_capture();
      t_hold();
      t_clear();
      t_uncr_capture();
      t_both_flags();
      t_same_cycle();
      t_scrub_off();
      t_no_flag();
      t_ro_write();
      $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
      $finish;
   end

endmodule